// File: doc/BRIEF.md
# Burst-Aware Rearbitration Gate

This block sits beside the arbiter of a shared slave port. It tells the arbiter when the master that currently owns the port may lose it. The owner might be running a burst whose length is not known in advance. It keeps a 3-bit rule for each of eight masters. Software sets the rules through a small register bus, and only privileged word-sized accesses reach them.

For each burst the block records whether the burst has an open length or a fixed length. It counts the accepted data beats. It drives `rearb_ok` from the counted beats and the rule of the master named on `owner_id`. The counted value saturates. A rule written during a burst governs the very next cycle, so a burst already in progress has no protection from the change.

The arbiter reads `rearb_ok` every cycle. A high level means it may hand the port to another requester. While no burst is in progress the signal is high.

Top module: `burst_rearb_ctrl`

## Requirements
- R1: After reset every rule field reads as 0, and `rearb_ok` is 1.
- R2: The rule of master n sits at byte offset 0x800 + n*0x100 in bits [2:0]. A legal read returns the value last written there, with bits [31:3] as zero. A legal access raises `reg_ack` one cycle after the request. A legal access is one with `reg_priv`=1 and `reg_size`=2'b10 (32-bit).
- R3: An access is refused when it is unprivileged, when it is not 32-bit, or when its offset is not one of the eight rule slots. A refused access raises `reg_err` for one cycle instead of `reg_ack`, changes no rule, and returns zero data.
- R4: Rule 3'b000 keeps `rearb_ok` at 0 for the whole of an open-length burst.
- R5: Rule 3'b001 makes `rearb_ok` 1 on every cycle of an open-length burst.
- R6: Rules 3'b010, 3'b011 and 3'b100 raise `rearb_ok` once 4, 8 or 16 beats of the open-length burst have been accepted. The signal then stays 1 until the burst ends.
- R7: Codes 3'b101, 3'b110 and 3'b111 behave exactly like 3'b000.
- R8: During a fixed-length burst `rearb_ok` is 0 until the last beat is accepted.
- R9: The beat count restarts at each `bus_start`, counting 1 if a beat is accepted in the same cycle. It saturates at 16.
- R10: A rule write takes effect on the cycle after the request, including during a burst already in progress.
- R11: When no burst is in progress, `rearb_ok` is 1. A burst ends on the cycle after a beat with `bus_last` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Register access request, one cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_priv | input | 1 | Request is privileged |
| reg_size | input | 2 | Access size: 00 byte, 01 half, 10 word |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with `reg_ack` |
| reg_ack | output | 1 | Legal access completed |
| reg_err | output | 1 | Access refused |
| owner_id | input | 3 | Master currently owning the port |
| bus_start | input | 1 | A new burst begins this cycle |
| bus_undef | input | 1 | The starting burst has an open length |
| bus_beat | input | 1 | A data beat is accepted this cycle |
| bus_last | input | 1 | The accepted beat is the final one |
| rearb_ok | output | 1 | Arbiter may rearbitrate the port now |

## Verification
The hardest case to reach is a rule changing while a long open-length burst is already past one threshold but not yet past the next. The cycle in which `rearb_ok` flips depends on both the saturated count and the write that lands mid-burst. The stimulus issues register writes in the same cycles as beats, with idle gaps between the beats. It runs bursts longer than 16 beats so that the count saturates. A behavioural reference in the bench, kept as plain integers, predicts every cycle of these sequences. The bench also switches `owner_id` during an idle period, and it restarts a burst before the previous one has finished.

// File: rtl/rearb_pkg.sv
package rearb_pkg;
   localparam int unsigned RULE_W = 3;

   typedef enum logic [RULE_W-1:0] {
      RULE_NEVER = 3'b000,
      RULE_ANY   = 3'b001,
      RULE_AFT4  = 3'b010,
      RULE_AFT8  = 3'b011,
      RULE_AFT16 = 3'b100
   } rule_e;

   localparam logic [1:0] SZ_WORD = 2'b10;

   // Largest beat threshold any rule can ask for.
   localparam int unsigned MAX_THRESH = 16;

   // Unlisted codes fall to the default branch and forbid rearbitration.
   function automatic logic rule_allows(input logic [RULE_W-1:0] code,
                                        input int unsigned beats);
      case (code)
         RULE_ANY:   return 1'b1;
         RULE_AFT4:  return beats >= 4;
         RULE_AFT8:  return beats >= 8;
         RULE_AFT16: return beats >= 16;
         default:    return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/rearb_regs.sv
module rearb_regs
   import rearb_pkg::*;
#(
   parameter int unsigned N_MST       = 8,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned BASE_OFF    = 'h800,
   parameter int unsigned STRIDE_LOG2 = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_req,
   input  logic                      reg_wr,
   input  logic                      reg_priv,
   input  logic [1:0]                reg_size,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [DATA_W-1:0]         reg_wdata,
   output logic [DATA_W-1:0]         reg_rdata,
   output logic                      reg_ack,
   output logic                      reg_err,
   output logic [N_MST*RULE_W-1:0]   rule_flat
);
   localparam int unsigned IDX_W = $clog2(N_MST);

   logic [ADDR_W-1:0] off;
   logic              in_win, legal, wr_en;
   logic [IDX_W-1:0]  slot;
   logic [RULE_W-1:0] rule_q [N_MST];
   logic [DATA_W-1:0] rd_d;
   logic              unused_wdata;

   assign off    = reg_addr - ADDR_W'(BASE_OFF);
   assign in_win = (reg_addr >= ADDR_W'(BASE_OFF))
                && (off[STRIDE_LOG2-1:0] == '0)
                && ((off >> STRIDE_LOG2) < ADDR_W'(N_MST));
   assign slot   = off[STRIDE_LOG2 +: IDX_W];
   assign legal  = reg_req && reg_priv && (reg_size == SZ_WORD) && in_win;
   assign wr_en  = legal && reg_wr;
   assign unused_wdata = ^reg_wdata[DATA_W-1:RULE_W];

   for (genvar g = 0; g < N_MST; g++) begin : g_rule
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rule_q[g] <= '0;
         else if (wr_en && (slot == IDX_W'(g)))
            rule_q[g] <= reg_wdata[RULE_W-1:0];
      end
      assign rule_flat[g*RULE_W +: RULE_W] = rule_q[g];
   end

   always_comb begin
      rd_d = '0;
      if (legal && !reg_wr)
         rd_d[RULE_W-1:0] = rule_q[slot];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_ack   <= 1'b0;
         reg_err   <= 1'b0;
         reg_rdata <= '0;
      end else begin
         reg_ack   <= legal;
         reg_err   <= reg_req && !legal;
         reg_rdata <= rd_d;
      end
   end

   p_resp_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_ack && reg_err));
   p_err_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_err |-> (reg_rdata == '0));
   p_user_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_req && !reg_priv) |-> $stable(rule_flat));
endmodule

// File: rtl/rearb_beat_ctr.sv
module rearb_beat_ctr #(
   parameter int unsigned CNT_MAX = 16,
   localparam int unsigned CW     = $clog2(CNT_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_start,
   input  logic          bus_undef,
   input  logic          bus_beat,
   input  logic          bus_last,
   output logic          active,
   output logic          open_len,
   output logic [CW-1:0] beats
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         open_len <= 1'b0;
         beats    <= '0;
      end else if (bus_start) begin
         active   <= !(bus_beat && bus_last);
         open_len <= bus_undef;
         beats    <= CW'(bus_beat);
      end else if (active && bus_beat) begin
         if (beats != CW'(CNT_MAX))
            beats <= beats + 1'b1;
         if (bus_last)
            active <= 1'b0;
      end
   end

   p_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      beats <= CW'(CNT_MAX));
   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_start) |-> (beats <= 1));
endmodule

// File: rtl/rearb_gate.sv
module rearb_gate
   import rearb_pkg::*;
#(
   parameter int unsigned N_MST = 8,
   parameter int unsigned CW    = 5,
   localparam int unsigned IDX_W = $clog2(N_MST)
) (
   input  logic [N_MST*RULE_W-1:0] rule_flat,
   input  logic [IDX_W-1:0]        owner_id,
   input  logic                    active,
   input  logic                    open_len,
   input  logic [CW-1:0]           beats,
   output logic                    rearb_ok
);
   logic [RULE_W-1:0] own_rule;

   assign own_rule = rule_flat[owner_id*RULE_W +: RULE_W];

   always_comb begin
      if (!active)
         rearb_ok = 1'b1;
      else if (!open_len)
         rearb_ok = 1'b0;
      else
         rearb_ok = rule_allows(own_rule, 32'(beats));
   end
endmodule

// File: rtl/burst_rearb_ctrl.sv
module burst_rearb_ctrl
   import rearb_pkg::*;
#(
   parameter int unsigned N_MST       = 8,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned BASE_OFF    = 'h800,
   parameter int unsigned STRIDE_LOG2 = 8,
   parameter int unsigned CNT_MAX     = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_req,
   input  logic                       reg_wr,
   input  logic                       reg_priv,
   input  logic [1:0]                 reg_size,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [DATA_W-1:0]          reg_wdata,
   output logic [DATA_W-1:0]          reg_rdata,
   output logic                       reg_ack,
   output logic                       reg_err,
   input  logic [$clog2(N_MST)-1:0]   owner_id,
   input  logic                       bus_start,
   input  logic                       bus_undef,
   input  logic                       bus_beat,
   input  logic                       bus_last,
   output logic                       rearb_ok
);
   localparam int unsigned CW = $clog2(CNT_MAX + 1);

   if (N_MST < 2) begin : g_chk_nmst
      $error("N_MST must be at least 2");
   end
   if (BASE_OFF + (N_MST << STRIDE_LOG2) > (1 << ADDR_W)) begin : g_chk_map
      $error("rule slots do not fit the address width");
   end
   if (STRIDE_LOG2 + $clog2(N_MST) > ADDR_W) begin : g_chk_stride
      $error("stride too wide for the address");
   end
   if (CNT_MAX < MAX_THRESH) begin : g_chk_cnt
      $error("CNT_MAX below the largest beat threshold");
   end
   if (DATA_W <= RULE_W) begin : g_chk_data
      $error("DATA_W must exceed the rule width");
   end

   logic [N_MST*RULE_W-1:0] rule_flat;
   logic                    active, open_len;
   logic [CW-1:0]           beats;

   rearb_regs #(
      .N_MST(N_MST), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .BASE_OFF(BASE_OFF), .STRIDE_LOG2(STRIDE_LOG2)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr),
      .reg_priv(reg_priv), .reg_size(reg_size), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
      .reg_err(reg_err), .rule_flat(rule_flat)
   );

   rearb_beat_ctr #(.CNT_MAX(CNT_MAX)) u_ctr (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_undef(bus_undef),
      .bus_beat(bus_beat), .bus_last(bus_last), .active(active),
      .open_len(open_len), .beats(beats)
   );

   rearb_gate #(.N_MST(N_MST), .CW(CW)) u_gate (
      .rule_flat(rule_flat), .owner_id(owner_id), .active(active),
      .open_len(open_len), .beats(beats), .rearb_ok(rearb_ok)
   );

   logic [RULE_W-1:0] own_rule;
   assign own_rule = rule_flat[owner_id*RULE_W +: RULE_W];

   p_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && open_len && own_rule == RULE_NEVER) |-> !rearb_ok);
   p_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && open_len && own_rule == RULE_ANY) |-> rearb_ok);
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rearb_ok) && $past(active) && active && !$past(bus_start)
       && $stable(own_rule) && $stable(owner_id)) |-> rearb_ok);
   p_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && own_rule > RULE_AFT16) |-> !rearb_ok);
   p_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !open_len) |-> !rearb_ok);
   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> rearb_ok);
endmodule

// File: tb/sim_burst_rearb_ctrl.sv
`timescale 1ns/1ps
module sim_burst_rearb_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_req = 0, reg_wr = 0, reg_priv = 0;
   logic [1:0]  reg_size = 0;
   logic [11:0] reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic        reg_ack, reg_err;
   logic [2:0]  owner_id = 0;
   logic        bus_start = 0, bus_undef = 0, bus_beat = 0, bus_last = 0;
   logic        rearb_ok;

   int n_chk = 0, n_fail = 0;
   string reg_tag = "R1";
   string ok_tag  = "";

   // reference state
   int  m_rule [8];
   bit  m_act, m_open, m_ack, m_err;
   int  m_beats;
   int  m_rd;

   always #4 clk = ~clk;

   burst_rearb_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr),
      .reg_priv(reg_priv), .reg_size(reg_size), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
      .reg_err(reg_err), .owner_id(owner_id), .bus_start(bus_start),
      .bus_undef(bus_undef), .bus_beat(bus_beat), .bus_last(bus_last),
      .rearb_ok(rearb_ok)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_rule[i]) m_rule[i] = 0;
         m_act = 0; m_open = 0; m_beats = 0; m_ack = 0; m_err = 0; m_rd = 0;
      end else begin
         m_ack = 0; m_err = 0; m_rd = 0;
         if (reg_req) begin
            if (reg_priv && reg_size == 2 && reg_addr >= 'h800 && reg_addr[7:0] == 0) begin
               m_ack = 1;
               if (reg_wr) m_rule[(reg_addr - 'h800) >> 8] = reg_wdata[2:0];
               else        m_rd = m_rule[(reg_addr - 'h800) >> 8];
            end else m_err = 1;
         end
         if (bus_start) begin
            m_act = !(bus_beat && bus_last); m_open = bus_undef; m_beats = bus_beat;
         end else if (m_act && bus_beat) begin
            if (m_beats < 16) m_beats++;
            if (bus_last) m_act = 0;
         end
      end
   end

   function automatic bit exp_ok();
      if (!m_act) return 1;
      if (!m_open) return 0;
      case (m_rule[owner_id])
         1: return 1;
         2: return m_beats >= 4;
         3: return m_beats >= 8;
         4: return m_beats >= 16;
         default: return 0;
      endcase
   endfunction

   function automatic string ok_req();
      if (ok_tag != "") return ok_tag;
      if (!m_act) return "R11";
      if (!m_open) return "R8";
      case (m_rule[owner_id])
         0: return "R4";
         1: return "R5";
         2, 3, 4: return m_beats >= 16 ? "R9" : "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
      check(ok_req(), rearb_ok, exp_ok());
      check(reg_tag, reg_ack, m_ack);
      check("R3", reg_err, m_err);
      check(reg_tag, reg_rdata, m_rd);
   endtask

   task automatic acc(input bit wr, input logic [11:0] a, input logic [31:0] d,
                      input bit priv, input logic [1:0] sz);
      reg_req = 1; reg_wr = wr; reg_addr = a; reg_wdata = d;
      reg_priv = priv; reg_size = sz;
      cyc();
      reg_req = 0; reg_wr = 0;
   endtask

   task automatic burst(input int own, input bit open, input int nb, input int gap);
      owner_id = 3'(own); bus_start = 1; bus_undef = open; bus_beat = 0; bus_last = 0;
      cyc();
      bus_start = 0;
      for (int i = 0; i < nb; i++) begin
         for (int j = 0; j < gap; j++) begin bus_beat = 0; cyc(); end
         bus_beat = 1; bus_last = (i == nb - 1);
         cyc();
      end
      bus_beat = 0; bus_last = 0;
      cyc();
   endtask

   initial begin
      #200_000_000;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset values and idle output
      check("R1", rearb_ok, 1);
      for (int n = 0; n < 8; n++) acc(0, 12'('h800 + n * 'h100), 0, 1, 2);
      reg_tag = "R2";
      // R2: map and read-back, upper bits ignored
      for (int n = 0; n < 8; n++) acc(1, 12'('h800 + n * 'h100), 32'hFFFF_FFF8 | 32'(n), 1, 2);
      for (int n = 0; n < 8; n++) acc(0, 12'('h800 + n * 'h100), 0, 1, 2);
      // R3: refused accesses leave rules untouched
      acc(1, 12'h900, 32'h4, 0, 2);
      acc(1, 12'h900, 32'h4, 1, 1);
      acc(1, 12'h904, 32'h4, 1, 2);
      acc(1, 12'h100, 32'h4, 1, 2);
      acc(0, 12'h900, 0, 0, 2);
      acc(0, 12'h900, 0, 1, 2);
      // R4..R7: one open burst per rule, with and without gaps
      for (int n = 0; n < 8; n++) burst(n, 1, 20, n % 2);
      // R8: fixed-length bursts under permissive rules
      burst(1, 0, 6, 0);
      burst(4, 0, 18, 1);
      // owner change while idle, then a single-beat burst started with its beat
      owner_id = 3'd3; cyc();
      owner_id = 3'd1; bus_start = 1; bus_undef = 1; bus_beat = 1; bus_last = 1; cyc();
      bus_start = 0; bus_beat = 0; bus_last = 0; cyc();
      // R9: restart mid-burst resets the count
      owner_id = 3'd2; bus_start = 1; bus_undef = 1; cyc();
      bus_start = 0; bus_beat = 1;
      repeat (6) cyc();
      bus_start = 1; bus_beat = 1; cyc();
      bus_start = 0;
      repeat (5) cyc();
      bus_last = 1; cyc();
      bus_beat = 0; bus_last = 0; cyc();
      // R10: rule rewritten in the middle of an open burst
      ok_tag = "R10";
      owner_id = 3'd0; bus_start = 1; bus_undef = 1; cyc();
      bus_start = 0; bus_beat = 1;
      repeat (5) cyc();
      acc(1, 12'h800, 32'h2, 1, 2);
      cyc();
      acc(1, 12'h800, 32'h4, 1, 2);
      repeat (3) cyc();
      acc(1, 12'h800, 32'h1, 1, 2);
      acc(1, 12'h800, 32'h6, 1, 2);
      repeat (14) cyc();
      bus_last = 1; cyc();
      bus_beat = 0; bus_last = 0; cyc();
      ok_tag = "";
      repeat (2) cyc();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule